// File: doc/BRIEF.md
# Slot-Ordered FIFO Request Sequencer

This block decides when a DMA channel may start and which FIFOs it visits, and in what order. Request lines from the FIFOs are captured in sticky flags. A configurable mask names the requests the channel depends on. When every one of those flags is set, the block raises a one-cycle start pulse. It then walks a programmed range of a 16-slot order table and presents one 4-bit FIFO number per slot on a valid/ready output.

There are two request sources. In per-FIFO mode the block watches 16 lines. In grouped mode it watches 4 lines and uses only the low four mask bits. Software can discard the captured flags that the mask selects by raising a clear strobe. The clear acts for exactly one cycle and then drops by itself. The order table arrives as two packed 32-bit words. Both words are shared by every channel of one direction, so this block only reads them.

The index output follows the usual stream rules. An index is transferred in a cycle where `idx_valid` and `idx_ready` are both high. While `idx_ready` is low, the block keeps `idx_valid` high and keeps `idx_fifo` unchanged. The walk never skips a slot and never moves ahead of the consumer.

Top module: `fifo_slot_sequencer`

## Requirements
- R1: A request line that is high at one rising edge sets a sticky flag. That flag stays set after the line drops, until it is consumed by a start or discarded by a clear.
- R2: In per-FIFO mode (`cfg_group_mode`=0), mask bit n selects request line `stream_req[n]`. `activate` is high for one cycle, in the cycle after the edge that captured the last missing selected request, and only if every selected flag is set.
- R3: In grouped mode (`cfg_group_mode`=1), only `group_req[3:0]` and mask bits [3:0] are used. Mask bits [15:4] and all `stream_req` lines have no effect.
- R4: A start discards the selected flags it used. A selected request line that is high at the start edge is captured again and leads to a second start.
- R5: A high `req_clear` sampled at an edge causes the selected flags to be discarded at the following edge. No start happens in the cycle between those two edges. The clear acts once per strobe.
- R6: Table slot n holds a 4-bit FIFO number. For n = 0..7 it is `cfg_order_lo[4n+3:4n]`. For n = 8..15 it is `cfg_order_hi[4(n-8)+3:4(n-8)]`.
- R7: After a start, the cycle that follows presents the table entry of `cfg_first_slot`. Each accepted transfer then moves to the next slot, up to and including `cfg_last_slot`. If the last slot is below the first slot, the walk wraps from 15 to 0.
- R8: While `idx_valid` is high and `idx_ready` is low, `idx_valid` stays high and `idx_fifo` does not change on the next cycle.
- R9: `walk_done` is high for one cycle, in the cycle after the transfer of the last slot. No start happens while a walk is in progress. Requests captured during a walk stay captured.
- R10: An all-zero effective mask never produces a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stream_req | input | 16 | Per-FIFO request lines |
| group_req | input | 4 | Grouped request lines |
| cfg_group_mode | input | 1 | 1 selects grouped requests |
| cfg_req_mask | input | 16 | Requests the channel depends on |
| cfg_first_slot | input | 4 | First table slot of the walk |
| cfg_last_slot | input | 4 | Last table slot of the walk |
| cfg_order_lo | input | 32 | Packed table slots 0..7 |
| cfg_order_hi | input | 32 | Packed table slots 8..15 |
| req_clear | input | 1 | Strobe that discards the selected captured flags |
| idx_ready | input | 1 | Consumer accepts the current index |
| activate | output | 1 | One-cycle channel start pulse |
| idx_valid | output | 1 | FIFO number on `idx_fifo` is valid |
| idx_fifo | output | 4 | FIFO number for the current slot |
| walk_done | output | 1 | One-cycle pulse after the final slot |

## Verification
Some properties are checked by assertions on every cycle:
- the index and its valid flag hold steady under back-pressure;
- a walk starts at the first slot in the cycle after a start;
- `walk_done` comes right after a final transfer while the output is idle;
- a start or a clear leaves none of the selected flags set unless a request arrived in the same cycle.

Other behaviour only the bench scenarios can show:
- the exact FIFO order produced by the table packing, including the wrap from slot 15 to 0;
- the need for every selected request before a start;
- the masking in grouped mode;
- the double start caused by a request that overlaps a start;
- that requests captured during a stall are kept and acted on later.

// File: rtl/fifo_seq_pkg.sv
package fifo_seq_pkg;
  localparam int unsigned NUM_REQ    = 16;
  localparam int unsigned NUM_GRP    = 4;
  localparam int unsigned NUM_SLOTS  = 16;
  localparam int unsigned IDX_W      = 4;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS);
  localparam int unsigned SLOTS_PER_REG = REG_W / IDX_W;

  typedef logic [IDX_W-1:0]  fifo_idx_t;
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/seq_req_latch.sv
module seq_req_latch
  import fifo_seq_pkg::*;
#(
  parameter int unsigned N_REQ = NUM_REQ,
  parameter int unsigned N_GRP = NUM_GRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] stream_req,
  input  logic [N_GRP-1:0] group_req,
  input  logic             group_mode,
  input  logic [N_REQ-1:0] req_mask,
  input  logic             clear_set,
  input  logic             busy,
  output logic             fire
);
  localparam int unsigned PAD_W = N_REQ - N_GRP;

  logic [N_REQ-1:0] lat_q;
  logic [N_REQ-1:0] eff_src;
  logic [N_REQ-1:0] eff_mask;
  logic [N_REQ-1:0] drop_mask;
  logic             clr_q;
  logic             all_seen;

  // Mode selects which request source and which mask bits are live
  always_comb begin
    if (group_mode) begin
      eff_src  = {{PAD_W{1'b0}}, group_req};
      eff_mask = {{PAD_W{1'b0}}, req_mask[N_GRP-1:0]};
    end else begin
      eff_src  = stream_req;
      eff_mask = req_mask;
    end
  end

  assign all_seen  = (eff_mask != '0) && ((lat_q & eff_mask) == eff_mask);
  assign fire      = all_seen && !busy && !clr_q;
  assign drop_mask = (fire || clr_q) ? eff_mask : '0;

  // Self-clearing discard flag: lives for one cycle per strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= clear_set;
  end

  // Sticky flags; arrivals in the consuming cycle survive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= (lat_q & ~drop_mask) | eff_src;
  end

  p_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((lat_q & $past(eff_mask) & ~$past(eff_src)) == '0));

  p_clear_wipes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> ((lat_q & $past(eff_mask) & ~$past(eff_src)) == '0));

  p_empty_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mask == '0) |-> !fire);
endmodule

// File: rtl/seq_order_table.sv
module seq_order_table
  import fifo_seq_pkg::*;
#(
  parameter int unsigned SLOTS = NUM_SLOTS,
  parameter int unsigned W     = IDX_W,
  parameter int unsigned RW    = REG_W
) (
  input  logic [RW-1:0]              tbl_lo,
  input  logic [RW-1:0]              tbl_hi,
  input  logic [$clog2(SLOTS)-1:0]   slot,
  output logic [W-1:0]               fifo
);
  localparam int unsigned PER_REG = RW / W;

  logic [W-1:0] entry [SLOTS];

  // Unpack two packed registers into a slot array
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < PER_REG) begin : g_lo
      assign entry[g] = tbl_lo[g*W +: W];
    end else begin : g_hi
      assign entry[g] = tbl_hi[(g-PER_REG)*W +: W];
    end
  end

  assign fifo = entry[slot];
endmodule

// File: rtl/seq_slot_walker.sv
module seq_slot_walker
  import fifo_seq_pkg::*;
#(
  parameter int unsigned SLOTS = NUM_SLOTS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [$clog2(SLOTS)-1:0] first_slot,
  input  logic [$clog2(SLOTS)-1:0] last_slot,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [$clog2(SLOTS)-1:0] out_slot,
  output logic                     done
);
  localparam int unsigned SW = $clog2(SLOTS);
  localparam logic [SW-1:0] TOP_SLOT = SW'(SLOTS - 1);

  logic          busy_q;
  logic [SW-1:0] slot_q;
  logic          done_q;
  logic          xfer;
  logic [SW-1:0] slot_next;

  assign xfer      = busy_q && out_ready;
  assign slot_next = (slot_q == TOP_SLOT) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          slot_q <= first_slot;
        end
      end else if (xfer) begin
        if (slot_q == last_slot) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          slot_q <= slot_next;
        end
      end
    end
  end

  assign out_valid = busy_q;
  assign out_slot  = slot_q;
  assign done      = done_q;

  p_walk_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !out_valid) |=> (out_valid && out_slot == $past(first_slot)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slot)));

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && $past(out_valid && out_ready)));
endmodule

// File: rtl/fifo_slot_sequencer.sv
module fifo_slot_sequencer
  import fifo_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_REQ-1:0]   stream_req,
  input  logic [NUM_GRP-1:0]   group_req,
  input  logic                 cfg_group_mode,
  input  logic [NUM_REQ-1:0]   cfg_req_mask,
  input  logic [SLOT_W-1:0]    cfg_first_slot,
  input  logic [SLOT_W-1:0]    cfg_last_slot,
  input  logic [REG_W-1:0]     cfg_order_lo,
  input  logic [REG_W-1:0]     cfg_order_hi,
  input  logic                 req_clear,
  input  logic                 idx_ready,
  output logic                 activate,
  output logic                 idx_valid,
  output logic [IDX_W-1:0]     idx_fifo,
  output logic                 walk_done
);
  logic  fire;
  logic  walking;
  slot_t cur_slot;

  seq_req_latch #(.N_REQ(NUM_REQ), .N_GRP(NUM_GRP)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .stream_req (stream_req),
    .group_req  (group_req),
    .group_mode (cfg_group_mode),
    .req_mask   (cfg_req_mask),
    .clear_set  (req_clear),
    .busy       (walking),
    .fire       (fire)
  );

  seq_slot_walker #(.SLOTS(NUM_SLOTS)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fire),
    .first_slot (cfg_first_slot),
    .last_slot  (cfg_last_slot),
    .out_ready  (idx_ready),
    .out_valid  (walking),
    .out_slot   (cur_slot),
    .done       (walk_done)
  );

  seq_order_table #(.SLOTS(NUM_SLOTS), .W(IDX_W), .RW(REG_W)) u_table (
    .tbl_lo (cfg_order_lo),
    .tbl_hi (cfg_order_hi),
    .slot   (cur_slot),
    .fifo   (idx_fifo)
  );

  assign activate  = fire;
  assign idx_valid = walking;

  p_no_start_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> !activate);

  p_act_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    activate |=> !activate);
endmodule

// File: tb/fifo_slot_sequencer_bench.sv
module fifo_slot_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] stream_req = '0;
  logic [3:0]  group_req = '0;
  logic        cfg_group_mode = 1'b0;
  logic [15:0] cfg_req_mask = '0;
  logic [3:0]  cfg_first_slot = '0;
  logic [3:0]  cfg_last_slot = '0;
  logic [31:0] cfg_order_lo = 32'h3A5C_81E6;
  logic [31:0] cfg_order_hi = 32'h9D2F_40B7;
  logic        req_clear = 1'b0;
  logic        idx_ready = 1'b1;
  logic        activate, idx_valid, walk_done;
  logic [3:0]  idx_fifo;

  int n_checks = 0;
  int n_err = 0;
  int act_cnt = 0;
  int done_cnt = 0;
  logic [3:0] exp_q [$];
  logic       prev_stall = 1'b0;
  logic [3:0] prev_fifo = '0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  fifo_slot_sequencer u_fifo_slot_sequencer (
    .clk(clk), .rst_n(rst_n), .stream_req(stream_req), .group_req(group_req),
    .cfg_group_mode(cfg_group_mode), .cfg_req_mask(cfg_req_mask),
    .cfg_first_slot(cfg_first_slot), .cfg_last_slot(cfg_last_slot),
    .cfg_order_lo(cfg_order_lo), .cfg_order_hi(cfg_order_hi),
    .req_clear(req_clear), .idx_ready(idx_ready), .activate(activate),
    .idx_valid(idx_valid), .idx_fifo(idx_fifo), .walk_done(walk_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R6 packing, computed from the requirement
  function automatic logic [3:0] tbl_val(input int s);
    if (s < 8) return cfg_order_lo[4*s +: 4];
    else       return cfg_order_hi[4*(s-8) +: 4];
  endfunction

  // Driver side of the scoreboard: expected R7 slot order
  task automatic push_walk(input int first, input int last);
    int s = first;
    forever begin
      exp_q.push_back(tbl_val(s));
      if (s == last) break;
      s = (s + 1) % 16;
    end
  endtask

  task automatic pulse_stream(input logic [15:0] v);
    @(negedge clk) stream_req = v;
    @(negedge clk) stream_req = '0;
  endtask

  task automatic pulse_group(input logic [3:0] v);
    @(negedge clk) group_req = v;
    @(negedge clk) group_req = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!idx_valid && exp_q.size() == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pop and compare, check hold under back-pressure, count pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (activate) act_cnt++;
      if (walk_done) done_cnt++;
      if (prev_stall)
        check(idx_valid && idx_fifo == prev_fifo, "R8 hold", idx_fifo, prev_fifo);
      if (idx_valid && idx_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected index", idx_fifo, 0);
        else begin
          automatic logic [3:0] e = exp_q.pop_front();
          check(idx_fifo == e, "R6/R7 order", idx_fifo, e);
        end
      end
      prev_stall = idx_valid && !idx_ready;
      prev_fifo  = idx_fifo;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    int a0;
    int d0;
    repeat (3) @(negedge clk);
    check(!activate && !idx_valid && !walk_done, "reset outputs", activate, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R2: both selected requests needed, captured at different times
    cfg_req_mask = 16'h0005; cfg_first_slot = 4'd2; cfg_last_slot = 4'd5;
    a0 = act_cnt; d0 = done_cnt;
    pulse_stream(16'h0001);
    check(!activate, "R2 partial mask", activate, 0);
    repeat (3) @(negedge clk);
    check(act_cnt == a0, "R1 no early start", act_cnt, a0);
    push_walk(2, 5);
    pulse_stream(16'h0004);
    check(activate, "R1/R2 start after last request", activate, 1);
    wait_idle();
    check(act_cnt == a0 + 1, "R2 single start", act_cnt, a0 + 1);
    check(done_cnt == d0 + 1, "R9 done pulse", done_cnt, d0 + 1);

    // R7 wrap from slot 15 to 0
    cfg_req_mask = 16'h8000; cfg_first_slot = 4'd14; cfg_last_slot = 4'd1;
    a0 = act_cnt;
    push_walk(14, 1);
    pulse_stream(16'h8000);
    check(activate, "R7 wrap start", activate, 1);
    wait_idle();
    check(exp_q.size() == 0, "R7 wrap all slots", exp_q.size(), 0);

    // R4: request overlapping the start is captured again
    cfg_req_mask = 16'h0001; cfg_first_slot = 4'd3; cfg_last_slot = 4'd3;
    a0 = act_cnt;
    push_walk(3, 3); push_walk(3, 3);
    @(negedge clk) stream_req = 16'h0001;
    @(negedge clk);
    check(activate, "R4 first start", activate, 1);
    @(negedge clk) stream_req = '0;
    wait_idle();
    check(act_cnt == a0 + 2, "R4 second start from overlap", act_cnt, a0 + 2);
    repeat (5) @(negedge clk);
    check(act_cnt == a0 + 2, "R4 consumed flags", act_cnt, a0 + 2);

    // R8/R9: stall, request arriving mid-walk waits for the end
    cfg_req_mask = 16'h0010; cfg_first_slot = 4'd5; cfg_last_slot = 4'd9;
    a0 = act_cnt; d0 = done_cnt;
    idx_ready = 1'b0;
    push_walk(5, 9);
    pulse_stream(16'h0010);
    check(activate, "R2 start under stall", activate, 1);
    pulse_stream(16'h0010);
    repeat (4) @(negedge clk);
    check(act_cnt == a0 + 1, "R9 no start while walking", act_cnt, a0 + 1);
    push_walk(5, 9);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk) idx_ready = (i % 3 == 2);
    end
    idx_ready = 1'b1;
    wait_idle();
    check(act_cnt == a0 + 2, "R9 captured request kept", act_cnt, a0 + 2);
    check(done_cnt == d0 + 2, "R9 done per walk", done_cnt, d0 + 2);

    // R5: clear discards selected flags
    cfg_req_mask = 16'h0003; cfg_first_slot = 4'd0; cfg_last_slot = 4'd0;
    a0 = act_cnt;
    pulse_stream(16'h0001);
    @(negedge clk) req_clear = 1'b1;
    @(negedge clk) req_clear = 1'b0;
    pulse_stream(16'h0002);
    check(!activate, "R5 flag cleared", activate, 0);
    repeat (3) @(negedge clk);
    check(act_cnt == a0, "R5 no start after clear", act_cnt, a0);
    push_walk(0, 0);
    pulse_stream(16'h0001);
    check(activate, "R5 start after refill", activate, 1);
    wait_idle();

    // R3: grouped mode ignores stream lines and high mask bits
    cfg_group_mode = 1'b1; cfg_req_mask = 16'hFF02;
    cfg_first_slot = 4'd8; cfg_last_slot = 4'd10;
    a0 = act_cnt;
    pulse_stream(16'hFFFF);
    check(!activate, "R3 stream ignored", activate, 0);
    pulse_group(4'b0001);
    check(!activate, "R3 unselected group", activate, 0);
    push_walk(8, 10);
    pulse_group(4'b0010);
    check(activate, "R3 group start", activate, 1);
    wait_idle();
    check(act_cnt == a0 + 1, "R3 one start", act_cnt, a0 + 1);

    // R10: empty mask never starts
    cfg_group_mode = 1'b0; cfg_req_mask = 16'h0000;
    a0 = act_cnt;
    pulse_stream(16'hFFFF);
    repeat (4) @(negedge clk);
    check(act_cnt == a0, "R10 empty mask", act_cnt, a0);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule